// File: doc/BRIEF.md
# Parallel ATA device register file

This block is the device end of a parallel ATA register interface. The host reaches it through two active-high chip selects and a 3-bit address. The command chip select opens eight task-file registers, and the control chip select opens one register at address 6. The block holds the addressing parameters the host writes, the 16-bit data word, and the features byte. It also holds the busy, data-request and error bits, plus an interrupt that is waiting for the host.

When the host writes a command, the block sets busy at once and passes the opcode and features byte to a command sequencer as a one-cycle pulse. The sequencer ends the command with a finish pulse. That pulse loads the error register with a result or diagnostic code, sets data-request and error as the sequencer asks, and raises the interrupt. The device answers only while the device bit of the device/head register matches its own identity.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 40h (only device-ready, bit 6, set), the error register reads 01h (the "no error" diagnostic code), and intrq is low.
- R2: Command-select addresses 2 to 6 are 8-bit registers that read back what was written. Address 0 is a 16-bit data register. Reads of 8-bit registers return zero in bits 15:8.
- R3: Status, read at command-select address 7, has busy at bit 7, device-ready (always 1) at bit 6, data-request at bit 3 and error at bit 0, with all other bits 0. The alternate status at control-select address 6 returns the same byte.
- R4: A write to command-select address 7 while the device is selected sets busy and clears data-request and error from the next cycle. In that same next cycle, cmd_valid is high for exactly one cycle, with cmd_code equal to the written byte and cmd_features equal to the last byte written to address 1.
- R5: While busy is set, writes to command-select addresses 0 to 6 have no effect.
- R6: A finish pulse clears busy, loads data-request and error from fin_drq and fin_err, loads the error register with fin_code, and makes an interrupt pending. The codes 01h, 02h and 03h report no error, a register compare fault and a buffer compare fault respectively.
- R7: A status read by the selected device clears the pending interrupt from the next cycle. An alternate status read leaves it pending.
- R8: Bit 1 of the control register (written at control-select address 6) masks intrq while set. The pending state is kept, and intrq returns when the mask bit is cleared.
- R9: Bit 4 of the device/head register selects the device; the block answers when it equals DEV_ID. When the block is not selected, it drives neither read data enable nor intrq, and it ignores command writes.
- R10: An access with both chip selects high, or with the control select at an address other than 6, has no effect and returns no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_cmd | input | 1 | Select for the command register group |
| host_cs_ctl | input | 1 | Select for the control register group |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data |
| host_rdata_en | output | 1 | High when the block drives read data |
| intrq | output | 1 | Interrupt request to the host |
| cmd_valid | output | 1 | One-cycle pulse for a new command |
| cmd_code | output | 8 | Command opcode |
| cmd_features | output | 8 | Features byte for the command |
| fin_valid | input | 1 | Sequencer finish pulse |
| fin_drq | input | 1 | Data-request value to load at finish |
| fin_err | input | 1 | Error bit value to load at finish |
| fin_code | input | 8 | Error or diagnostic code to load at finish |

## Verification
The hardest cases involve the interrupt, which is cleared only as a side effect of one specific read. The stimulus separates three situations that all look like "intrq low": a real clear, a mask, and a deselected device. It builds a pending interrupt, then reads the alternate status. It then sets the mask and runs a whole command under it, switches the device bit away and back, and only then reads status. A behavioural model running beside the design compares intrq, the command pulse and read data on every cycle.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter bit DEV_ID = 1'b0,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_cmd,
  input  logic          host_cs_ctl,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_en,
  output logic          intrq,
  output logic          cmd_valid,
  output logic [7:0]    cmd_code,
  output logic [7:0]    cmd_features,
  input  logic          fin_valid,
  input  logic          fin_drq,
  input  logic          fin_err,
  input  logic [7:0]    fin_code
);
  localparam int PAD = DW - 8;
  localparam logic [2:0] A_STAT = 3'd7;
  localparam logic [2:0] A_DEVH = 3'd6;
  localparam logic [7:0] DIAG_OK = 8'h01;

  logic [DW-1:0] data_q;
  logic [7:0] err_q, feat_q, cnt_q, num_q, cyl_lo_q, cyl_hi_q, devh_q, code_q;
  logic bsy, drq, errb, pend, nien, cmdv;

  wire in_cmd = host_cs_cmd & ~host_cs_ctl;
  wire in_ctl = host_cs_ctl & ~host_cs_cmd & (host_addr == A_DEVH);
  wire sel    = (devh_q[4] == DEV_ID);
  wire go     = host_wr & in_cmd & (host_addr == A_STAT) & sel;
  wire tf_wr  = host_wr & in_cmd & (host_addr != A_STAT) & ~bsy;
  wire rd_st  = host_rd & in_cmd & (host_addr == A_STAT) & sel;
  wire rd_alt = host_rd & in_ctl & sel;
  wire [7:0] status = {bsy, 1'b1, 2'b00, drq, 2'b00, errb};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0; err_q <= DIAG_OK; feat_q <= '0; cnt_q <= '0; num_q <= '0;
      cyl_lo_q <= '0; cyl_hi_q <= '0; devh_q <= '0; code_q <= '0;
      bsy <= 1'b0; drq <= 1'b0; errb <= 1'b0; pend <= 1'b0; nien <= 1'b0; cmdv <= 1'b0;
    end else begin
      cmdv <= 1'b0;
      if (rd_st) pend <= 1'b0;
      if (fin_valid) begin
        bsy <= 1'b0; drq <= fin_drq; errb <= fin_err; err_q <= fin_code; pend <= 1'b1;
      end
      if (host_wr && in_ctl) nien <= host_wdata[1];
      if (tf_wr) begin
        case (host_addr)
          3'd0: data_q   <= host_wdata;
          3'd1: feat_q   <= host_wdata[7:0];
          3'd2: cnt_q    <= host_wdata[7:0];
          3'd3: num_q    <= host_wdata[7:0];
          3'd4: cyl_lo_q <= host_wdata[7:0];
          3'd5: cyl_hi_q <= host_wdata[7:0];
          default: devh_q <= host_wdata[7:0];
        endcase
      end
      if (go) begin
        bsy <= 1'b1; drq <= 1'b0; errb <= 1'b0; pend <= 1'b0;
        cmdv <= 1'b1; code_q <= host_wdata[7:0];
      end
    end
  end

  logic [7:0] rd8;
  always_comb begin
    rd8 = status;
    if (in_cmd) begin
      case (host_addr)
        3'd1: rd8 = err_q;
        3'd2: rd8 = cnt_q;
        3'd3: rd8 = num_q;
        3'd4: rd8 = cyl_lo_q;
        3'd5: rd8 = cyl_hi_q;
        3'd6: rd8 = devh_q;
        default: rd8 = status;
      endcase
    end
  end

  assign host_rdata    = (in_cmd && host_addr == 3'd0) ? data_q : {{PAD{1'b0}}, rd8};
  assign host_rdata_en = host_rd & sel & (in_cmd | in_ctl);
  assign intrq         = pend & ~nien & sel;
  assign cmd_valid     = cmdv;
  assign cmd_code      = code_q;
  assign cmd_features  = feat_q;

  assert_cmd_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cmd_valid && status[7] && !status[3] && !status[0]));
  assert_busy_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && host_wr && in_cmd && host_addr == 3'd2) |=> $stable(cnt_q));
  assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !fin_valid) |=> !intrq);
  assert_alt_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_alt && !fin_valid && !go) |=> (pend == $past(pend)));
  assert_finish_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && !go) |=> (!status[7] && pend));
  assert_unselected_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!intrq && !host_rdata_en));
endmodule

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
  logic clk = 0, rst_n = 0;
  logic cs_cmd = 0, cs_ctl = 0, wr = 0, rd = 0, fin = 0, fdrq = 0, ferr = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [7:0] fcode = 0;
  logic [15:0] rdata; logic rden, irq, cv; logic [7:0] cc, cf;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ata_taskfile i_ata_taskfile (.clk(clk), .rst_n(rst_n), .host_cs_cmd(cs_cmd), .host_cs_ctl(cs_ctl),
    .host_addr(addr), .host_wr(wr), .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata),
    .host_rdata_en(rden), .intrq(irq), .cmd_valid(cv), .cmd_code(cc), .cmd_features(cf),
    .fin_valid(fin), .fin_drq(fdrq), .fin_err(ferr), .fin_code(fcode));

  // behavioural reference model
  int m_reg[8]; int m_data, m_feat, m_code; bit m_bsy, m_drq, m_err, m_pend, m_nien, m_cv;
  function automatic int m_status(); return (m_bsy << 7) | 'h40 | (m_drq << 3) | m_err; endfunction
  function automatic bit m_sel(); return ((m_reg[6] >> 4) & 1) == 0; endfunction

  always @(posedge clk) begin
    bit ac, ak, s, b;
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_reg[1] = 1; m_data = 0; m_feat = 0; m_code = 0;
      m_bsy = 0; m_drq = 0; m_err = 0; m_pend = 0; m_nien = 0; m_cv = 0;
    end else begin
      ac = cs_cmd && !cs_ctl; ak = cs_ctl && !cs_cmd && addr == 6; s = m_sel(); b = m_bsy;
      m_cv = 0;
      if (rd && ac && addr == 7 && s) m_pend = 0;
      if (fin) begin m_bsy = 0; m_drq = fdrq; m_err = ferr; m_reg[1] = fcode; m_pend = 1; end
      if (wr && ak) m_nien = wdata[1];
      if (wr && ac) begin
        if (addr == 7) begin
          if (s) begin m_bsy = 1; m_drq = 0; m_err = 0; m_pend = 0; m_cv = 1; m_code = wdata[7:0]; end
        end else if (!b) begin
          if (addr == 0) m_data = wdata;
          else if (addr == 1) m_feat = wdata[7:0];
          else m_reg[addr] = wdata[7:0];
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit ac, ak; int e;
    #3;
    if (rst_n) begin
      chk("R8 intrq vs model", irq, m_pend && !m_nien && m_sel());
      chk("R4 cmd_valid vs model", cv, m_cv);
      if (m_cv) begin chk("R4 cmd_code vs model", cc, m_code); chk("R4 features vs model", cf, m_feat); end
      ac = cs_cmd && !cs_ctl; ak = cs_ctl && !cs_cmd && addr == 6;
      chk("R10 rdata_en vs model", rden, rd && m_sel() && (ac || ak));
      if (rd && rden) begin
        if (ac && addr == 0) e = m_data;
        else if (ac && addr != 7) e = m_reg[addr];
        else e = m_status();
        chk("R2 rdata vs model", rdata, e);
      end
    end
  end

  task automatic do_wr(input bit ctl, input bit both, input int a, input int d);
    @(negedge clk); cs_cmd = !ctl || both; cs_ctl = ctl || both; addr = a[2:0]; wdata = d[15:0]; wr = 1;
    @(negedge clk); wr = 0; cs_cmd = 0; cs_ctl = 0;
  endtask
  task automatic do_rd(input bit ctl, input int a, output int v, output bit en);
    @(negedge clk); cs_cmd = !ctl; cs_ctl = ctl; addr = a[2:0]; rd = 1;
    #2; v = rdata; en = rden;
    @(negedge clk); rd = 0; cs_cmd = 0; cs_ctl = 0;
  endtask
  task automatic finish(input bit d, input bit e, input int code);
    @(negedge clk); fin = 1; fdrq = d; ferr = e; fcode = code[7:0];
    @(negedge clk); fin = 0;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v; bit en;
    repeat (3) @(negedge clk); rst_n = 1;
    do_rd(0, 7, v, en); chk("R1 status after reset", v, 'h40);
    do_rd(0, 1, v, en); chk("R1 error after reset", v, 'h01);
    chk("R1 intrq after reset", irq, 0);
    for (int a = 2; a <= 5; a++) do_wr(0, 0, a, 'hA0 + a);
    do_wr(0, 0, 6, 'hE0);
    do_wr(0, 0, 0, 'hBEEF);
    for (int a = 2; a <= 5; a++) begin do_rd(0, a, v, en); chk("R2 readback", v, 'hA0 + a); end
    do_rd(0, 6, v, en); chk("R2 devhead readback", v, 'hE0);
    do_rd(0, 0, v, en); chk("R2 16-bit data", v, 'hBEEF);
    do_rd(1, 6, v, en); chk("R3 alt status", v, 'h40);
    do_wr(0, 0, 1, 'h5A);
    @(negedge clk); cs_cmd = 1; addr = 7; wdata = 'hEC; wr = 1;
    @(negedge clk); wr = 0; cs_cmd = 0;
    chk("R4 cmd_valid pulse", cv, 1); chk("R4 cmd_code", cc, 'hEC); chk("R4 features", cf, 'h5A);
    @(negedge clk); chk("R4 single pulse", cv, 0);
    do_rd(0, 7, v, en); chk("R4 busy status", v, 'hC0);
    do_wr(0, 0, 2, 'h77);
    do_rd(0, 2, v, en); chk("R5 write ignored while busy", v, 'hA2);
    finish(1, 0, 'h01);
    do_rd(1, 6, v, en); chk("R6 status after finish", v, 'h48);
    chk("R6 intrq raised", irq, 1);
    chk("R7 alt read keeps intrq", irq, 1);
    do_rd(0, 7, v, en); chk("R7 status read clears intrq", irq, 0);
    do_wr(1, 0, 6, 'h02);
    do_wr(0, 0, 7, 'h20);
    finish(0, 1, 'h02);
    chk("R8 intrq masked", irq, 0);
    do_rd(0, 1, v, en); chk("R6 diag code 02h", v, 'h02);
    do_rd(1, 6, v, en); chk("R3 alt status err", v, 'h41);
    do_wr(1, 0, 6, 'h00);
    chk("R8 intrq after unmask", irq, 1);
    do_wr(0, 0, 6, 'hF0);
    chk("R9 intrq off when unselected", irq, 0);
    do_rd(0, 7, v, en); chk("R9 no read data unselected", en, 0);
    do_wr(0, 0, 7, 'h91);
    chk("R9 command ignored", cv, 0);
    do_wr(0, 0, 6, 'hE0);
    chk("R9 pending kept across deselect", irq, 1);
    do_rd(0, 7, v, en); chk("R9 status unchanged", v, 'h41);
    chk("R7 cleared by status read", irq, 0);
    do_wr(0, 1, 3, 'h11);
    do_rd(0, 3, v, en); chk("R10 both selects ignored", v, 'hA3);
    do_rd(1, 2, v, en); chk("R10 ctl other address no data", en, 0);
    do_wr(0, 0, 7, 'h90);
    finish(0, 0, 'h03);
    do_rd(0, 1, v, en); chk("R6 diag code 03h", v, 'h03);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule